// File: doc/BRIEF.md
# LCD Command-Port Framebuffer Writer

This block stands in for a small external display controller that a processor drives over two byte-wide write ports on its bus. One is the command port and the other is the data port. On the command port, a command code is accepted only after a 0x00 prefix byte. While the memory-write command (0x22) is the active command, bytes on the data port are packed into 16-bit RGB565 pixels. Each pixel goes into an on-block framebuffer, at a byte address that counts up by itself and wraps after one full frame.

The display side reads the framebuffer through a registered pixel port. It presents a pixel index with a read enable and receives the pixel, split into its colour fields as well, on the next cycle. The frame size sets the wrap point and defaults to 320 by 240 pixels. The number of pixels actually held is a separate parameter, so that a default build stays small. Pixels at or beyond that capacity are discarded on write and read back as zero.

Top module: `lcd_fb_writer`

## Requirements
- R1: After reset the command decoder is idle with no active command. The byte address is 0 and `rd_pix` reads 0x0000.
- R2: When the decoder is idle or running a command, a command-port byte of 0x00 moves it to the wait-for-code state and clears the active command. Any other command byte in those two states leaves both the state and the active command unchanged.
- R3: In the wait-for-code state, the next command-port byte is taken as the active command, and the decoder moves to the running state. This holds for any value, 0x00 included.
- R4: Both ports take only bits 7:0 of `wdata`. Bits 15:8 have no effect.
- R5: A data-port byte is stored only while the decoder is running command 0x22. In every other case it is dropped and the byte address does not move.
- R6: Each stored byte advances the byte address by one. The address returns to 0 after byte FRAME_W*FRAME_H*2-1, which is 153600 bytes with the default parameters. Commands never reset the address.
- R7: Pixel n is made of the byte at address 2n, which becomes bits 15:8, and the byte at 2n+1, which becomes bits 7:0. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0.
- R8: When `rd_en` is high, `rd_pix` and the three colour fields show pixel `rd_idx` after the next clock edge. An index at or beyond FB_PIXELS reads 0. While `rd_en` is low, the read outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command port |
| data_we | input | 1 | Write strobe for the data port |
| wdata | input | 16 | Bus write word; only bits 7:0 are used |
| rd_en | input | 1 | Pixel read enable |
| rd_idx | input | PIX_W | Pixel index to read |
| rd_pix | output | 16 | Registered RGB565 pixel |
| rd_red | output | 5 | Red field of `rd_pix` |
| rd_green | output | 6 | Green field of `rd_pix` |
| rd_blue | output | 5 | Blue field of `rd_pix` |

## Verification
A decoder stuck in the wrong state, or holding a stale command code, does not show up until the next data byte. That byte is either lost or stored when it should not be, and a read one cycle after the pixel completes exposes the mistake. A byte address that is off by one has a different signature. It swaps the byte halves of every following pixel, or shifts every pixel by one place, and the damage persists until the address wraps. The bench therefore places dropped data bytes between stored pixels. It then reads neighbouring pixels back, so that a slip in either the decoder or the address counter turns into a wrong pixel value within a few cycles.

// File: rtl/lcdfb_pkg.sv
package lcdfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_CODE = 2'd1,
    ST_RUN      = 2'd2
  } lcd_state_e;

  localparam logic [7:0] CMD_PREFIX    = 8'h00;
  localparam logic [7:0] CMD_MEM_WRITE = 8'h22;

  function automatic logic [15:0] join_bytes(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [4:0] pix_red(input logic [15:0] p);
    return p[15:11];
  endfunction

  function automatic logic [5:0] pix_green(input logic [15:0] p);
    return p[10:5];
  endfunction

  function automatic logic [4:0] pix_blue(input logic [15:0] p);
    return p[4:0];
  endfunction

endpackage

// File: rtl/lcdfb_cmd_fsm.sv
module lcdfb_cmd_fsm
  import lcdfb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  output lcd_state_e state_q,
  output logic [7:0] cmd_q,
  output logic       mem_write_mode
);

  lcd_state_e state_d;
  logic [7:0] cmd_d;
  logic       prefix_hit;
  logic       code_take;

  assign code_take  = cmd_we && (state_q == ST_WAIT_CODE);
  assign prefix_hit = cmd_we && (state_q != ST_WAIT_CODE) && (cmd_byte == CMD_PREFIX);

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    if (code_take) begin
      state_d = ST_RUN;
      cmd_d   = cmd_byte;
    end else if (prefix_hit) begin
      state_d = ST_WAIT_CODE;
      cmd_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
    end
  end

  assign mem_write_mode = (state_q == ST_RUN) && (cmd_q == CMD_MEM_WRITE);

  AST_PREFIX_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_byte == 8'h00 && state_q != ST_WAIT_CODE |=> state_q == ST_WAIT_CODE && cmd_q == 8'h00); // R2

  AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_byte != 8'h00 && state_q != ST_WAIT_CODE |=> $stable(state_q) && $stable(cmd_q)); // R2

  AST_CODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && state_q == ST_WAIT_CODE |=> state_q == ST_RUN && cmd_q == $past(cmd_byte)); // R3

endmodule

// File: rtl/lcdfb_byte_ctr.sv
module lcdfb_byte_ctr #(
  parameter int BYTES = 153600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [7:0]        byte_in,
  output logic [$clog2(BYTES)-1:0] addr_q,
  output logic              pix_we,
  output logic [$clog2(BYTES)-2:0] pix_idx,
  output logic [15:0]       pix_data
);
  import lcdfb_pkg::*;

  localparam int AW = $clog2(BYTES);
  localparam logic [AW-1:0] LAST = AW'(BYTES - 1);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + AW'(1);
  endfunction

  logic [7:0] hi_q;
  logic       at_wrap;

  assign at_wrap  = byte_we && (addr_q == LAST);
  assign pix_we   = byte_we && addr_q[0];
  assign pix_idx  = addr_q[AW-1:1];
  assign pix_data = join_bytes(hi_q, byte_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      hi_q   <= '0;
    end else if (byte_we) begin
      addr_q <= next_addr(addr_q);
      if (!addr_q[0]) hi_q <= byte_in;
    end
  end

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    at_wrap |=> addr_q == '0); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we && addr_q != LAST |=> addr_q == AW'($past(addr_q) + AW'(1))); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_we |=> $stable(addr_q)); // R5

endmodule

// File: rtl/lcdfb_pixel_store.sv
module lcdfb_pixel_store #(
  parameter int DEPTH = 4096,
  parameter int IDX_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data
);

  localparam int DW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [15:0] mem [DEPTH];
  logic        wr_in_range;
  logic        rd_in_range;

  assign wr_in_range = (32'(wr_idx) < DEPTH);
  assign rd_in_range = (32'(rd_idx) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) mem[DW'(wr_idx)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_in_range ? mem[DW'(rd_idx)] : 16'h0000;
    end
  end

  AST_RD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_in_range |=> rd_data == 16'h0000); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R8

endmodule

// File: rtl/lcd_fb_writer.sv
module lcd_fb_writer
  import lcdfb_pkg::*;
#(
  parameter int FRAME_W   = 320,
  parameter int FRAME_H   = 240,
  parameter int FB_PIXELS = 4096,
  parameter int PIX_W     = $clog2(FRAME_W * FRAME_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic             data_we,
  input  logic [15:0]      wdata,
  input  logic             rd_en,
  input  logic [PIX_W-1:0] rd_idx,
  output logic [15:0]      rd_pix,
  output logic [4:0]       rd_red,
  output logic [5:0]       rd_green,
  output logic [4:0]       rd_blue
);

  localparam int FRAME_PIX = FRAME_W * FRAME_H;
  localparam int BYTES     = FRAME_PIX * 2;
  localparam int AW        = $clog2(BYTES);
  localparam int STORE     = (FB_PIXELS < FRAME_PIX) ? FB_PIXELS : FRAME_PIX;

  lcd_state_e      state_q;
  logic [7:0]      cmd_q;
  logic            mem_write_mode;
  logic            byte_accept;
  logic [AW-1:0]   addr_q;
  logic            pix_we;
  logic [AW-2:0]   pix_idx;
  logic [15:0]     pix_data;
  logic [7:0]      bus_byte;

  assign bus_byte    = wdata[7:0];
  assign byte_accept = data_we && mem_write_mode;

  lcdfb_cmd_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_we         (cmd_we),
    .cmd_byte       (bus_byte),
    .state_q        (state_q),
    .cmd_q          (cmd_q),
    .mem_write_mode (mem_write_mode)
  );

  lcdfb_byte_ctr #(.BYTES(BYTES)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_we  (byte_accept),
    .byte_in  (bus_byte),
    .addr_q   (addr_q),
    .pix_we   (pix_we),
    .pix_idx  (pix_idx),
    .pix_data (pix_data)
  );

  lcdfb_pixel_store #(.DEPTH(STORE), .IDX_W(PIX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pix_we),
    .wr_idx  (PIX_W'(pix_idx)),
    .wr_data (pix_data),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_data (rd_pix)
  );

  assign rd_red   = pix_red(rd_pix);
  assign rd_green = pix_green(rd_pix);
  assign rd_blue  = pix_blue(rd_pix);

  AST_STORE_ONLY_MEMWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> state_q == ST_RUN && cmd_q == 8'h22 && data_we); // R5

  AST_DROP_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !(state_q == ST_RUN && cmd_q == 8'h22) |=> $stable(addr_q)); // R5

endmodule

// File: tb/lcd_fb_writer_bench.sv
`timescale 1ns/1ps
module lcd_fb_writer_bench;

  localparam int W = 8;
  localparam int H = 4;
  localparam int FBP = 24;
  localparam int PW = $clog2(W * H);

  logic clk = 0;
  logic rst_n = 0;
  logic cmd_we = 0, data_we = 0, rd_en = 0;
  logic [15:0] wdata = '0;
  logic [PW-1:0] rd_idx = '0;
  logic [15:0] rd_pix;
  logic [4:0] rd_red, rd_blue;
  logic [5:0] rd_green;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic pend = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  lcd_fb_writer #(.FRAME_W(W), .FRAME_H(H), .FB_PIXELS(FBP)) u_lcd_fb_writer (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .data_we(data_we), .wdata(wdata),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_pix(rd_pix), .rd_red(rd_red),
    .rd_green(rd_green), .rd_blue(rd_blue)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [15:0] v);
    cmd_we = 1; wdata = v;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic put_data(input logic [15:0] v);
    data_we = 1; wdata = v;
    @(negedge clk);
    data_we = 0;
  endtask

  task automatic put_pix(input int v);
    put_data(16'((v / 256) % 256));
    put_data(16'(v % 256));
  endtask

  // driver: issues a read and queues what the scoreboard must see
  task automatic read_pix(input int idx, input int exp, input string tag);
    rd_en = 1; rd_idx = PW'(idx);
    exp_q.push_back(16'(exp));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic int fill_val(input int i);
    return ((i * 16'h0841) ^ 16'h1357) % 65536;
  endfunction

  always @(posedge clk) pend <= rd_en;

  // monitor: compares each read result half a cycle after it is registered
  always @(negedge clk) begin
    if (pend && !done) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected read result", rd_pix, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_pix == e, t, rd_pix, e);
        check(rd_red == 5'(e / 2048) && rd_green == 6'((e / 32) % 64) && rd_blue == 5'(e % 32),
              {"R7 fields ", t}, {rd_red, rd_green, rd_blue}, e);
      end
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(rd_pix == 16'h0000, "R1 reset rd_pix", rd_pix, 0);

    // R5: dropped while idle; the address must stay at 0
    put_data(16'h0011);
    put_data(16'h0022);
    put_cmd(16'h0000);
    put_cmd(16'h0022);
    put_pix(16'hF81F);                 // pixel 0 (R1: address was 0)

    // R2: non-zero byte while running is ignored
    put_cmd(16'h0055);
    put_pix(16'h1234);                 // pixel 1

    // R4: prefix carried in bits 7:0 only
    put_cmd(16'hAB00);
    put_data(16'h0099);                // dropped while waiting (R5)
    put_cmd(16'h002C);                 // other command
    put_data(16'h0077);
    put_data(16'h0066);                // dropped (R5)
    put_cmd(16'h0000);
    put_cmd(16'h0000);                 // R3: 0x00 taken as code
    put_data(16'h0044);                // dropped
    put_cmd(16'h0000);
    put_cmd(16'h1122);                 // R4: code 0x22
    put_data(16'hFF07);
    put_data(16'h12E0);                // pixel 2 = 0x07E0 (R4)

    read_pix(0, 16'hF81F, "R5 R1 pixel0");
    read_pix(1, 16'h1234, "R2 pixel1");
    read_pix(2, 16'h07E0, "R4 R3 pixel2");
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(rd_pix == 16'h07E0, "R8 hold without rd_en", rd_pix, 16'h07E0);

    for (int i = 3; i < W * H; i++) put_pix(fill_val(i));
    put_pix(16'hBEEF);                 // wraps onto pixel 0 (R6)

    read_pix(0, 16'hBEEF, "R6 wrap pixel0");
    read_pix(1, 16'h1234, "R6 pixel1 kept");
    read_pix(5, fill_val(5), "R7 pixel5");
    read_pix(23, fill_val(23), "R7 pixel23");
    read_pix(24, 0, "R8 beyond capacity 24");
    read_pix(31, 0, "R8 beyond capacity 31");
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule